// File: doc/BRIEF.md
# Prioritized Interrupt Level Evaluator

This block merges two sources of interrupt requests into a single priority level. One source is a software request register that firmware writes. The other is a vector of external hardware request lines. When the block is armed, it computes the winning level and a summary vector of everything pending. It then compares the level against the current processor priority level. If the computed level is higher, it raises a trap request and latches the summary and the winning level as status outputs.

Arming works through a check-enable flag. The flag is set out of reset. An evaluation clears it, and a return-from-privileged-mode pulse sets it again. While a trap request is held, no further evaluation takes place until that pulse arrives. The same pulse also drops the trap request.

Software bits are renumbered into levels 1 to 15. External lines keep their bit position as their level. Any pending external line outranks every software request. A nonzero asynchronous-trap request seen during an evaluation is flagged as unsupported.

Top module: `ireq_eval`

## Requirements
- R1: A software write stores only bits 4 to 18 of the written word (mask 0x7fff0). Every other bit is dropped and never appears in the summary or the level.
- R2: A stored software bit at position i (4..18) gives level i-3. The highest pending software bit sets the software level.
- R3: External line k (0..10) gives level 20+k. The highest pending external line sets the external level.
- R4: If any external line is pending, the external level is used. This holds whatever the software level is.
- R5: The summary sets bit i for each stored software bit i, and bit 20+k for each pending external line k. No other bit is set.
- R6: An evaluation raises the trap only when the level is nonzero and strictly greater than the 5-bit `ipl_i`. Otherwise `trap_o` stays low and the summary and ID keep their values.
- R7: On a trapping evaluation, `trap_o`, `isr_o` and `intid_o` take their new values one clock after the evaluating edge. `isr_o` takes the summary and `intid_o` takes the level.
- R8: An evaluation happens on an edge where the check flag is set and `trap_o` is low, and it clears the flag. `rfe_i` sets the flag and drops `trap_o`. While `trap_o` is high and `rfe_i` is low, all outputs hold.
- R9: An evaluation with nonzero `ast_req_i` pulses `ast_err_o` high for one cycle.
- R10: During reset the check flag is set, and `trap_o`, `ast_err_o`, `isr_o` and `intid_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_we_i | input | 1 | Write strobe for the software request register |
| sw_wdata_i | input | 32 | Software request write data |
| ext_req_i | input | 11 | External request lines |
| ast_req_i | input | 4 | Asynchronous-trap request value |
| ipl_i | input | 5 | Current processor priority level |
| rfe_i | input | 1 | Return-from-privileged-mode pulse |
| trap_o | output | 1 | Interrupt trap request |
| isr_o | output | 32 | Latched interrupt summary |
| intid_o | output | 5 | Latched winning level |
| ast_err_o | output | 1 | Unsupported asynchronous-trap request seen |

## Verification
The level logic is driven with several kinds of input:
- A single low software bit, which checks the renumbering offset.
- Two software bits, which confirm that the highest bit wins and not the lowest.
- An all-ones write, which shows the mask.
- Two external lines, which check the raw-index level.
- A top software bit together with the lowest external line, which separates external precedence from numeric comparison.

The compare is tested at the priority level equal to the computed level and at one below it, to expose the strictness of the comparison. New trapping inputs are also applied both while a trap is held and after a non-trapping evaluation. This shows that the check flag, and not the inputs, gates evaluation.

// File: rtl/ireq_pkg.sv
package ireq_pkg;
  localparam int unsigned LVL_W  = 5;
  localparam int unsigned SUM_W  = 32;
  localparam int unsigned SW_LO  = 4;
  localparam int unsigned SW_N   = 15;
  localparam int unsigned EXT_LO = 20;
  localparam int unsigned EXT_N  = 11;
  localparam int unsigned AST_W  = 4;
endpackage

// File: rtl/ireq_swreg.sv
module ireq_swreg #(
  parameter int unsigned SUM_W = 32,
  parameter int unsigned SW_LO = 4,
  parameter int unsigned SW_N  = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SUM_W-1:0] wdata_i,
  output logic [SUM_W-1:0] req_o
);
  localparam logic [SUM_W-1:0] MASK = SUM_W'(((64'd1 << SW_N) - 64'd1) << SW_LO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   req_o <= '0;
    else if (we_i) req_o <= wdata_i & MASK;
  end
endmodule

// File: rtl/ireq_prio.sv
module ireq_prio #(
  parameter int unsigned SUM_W  = 32,
  parameter int unsigned LVL_W  = 5,
  parameter int unsigned SW_LO  = 4,
  parameter int unsigned SW_N   = 15,
  parameter int unsigned EXT_LO = 20,
  parameter int unsigned EXT_N  = 11
) (
  input  logic [SUM_W-1:0] sw_req_i,
  input  logic [EXT_N-1:0] ext_req_i,
  output logic [LVL_W-1:0] lvl_o,
  output logic [SUM_W-1:0] sum_o
);
  localparam logic [SUM_W-1:0] SW_MASK = SUM_W'(((64'd1 << SW_N) - 64'd1) << SW_LO);

  logic [SUM_W-1:0] ext_pos;
  logic [LVL_W-1:0] sw_lvl, ext_lvl;

  // place external lines at their own summary positions
  for (genvar b = 0; b < SUM_W; b++) begin : g_pos
    if (b >= EXT_LO && b < EXT_LO + EXT_N) begin : g_ext
      assign ext_pos[b] = ext_req_i[b-EXT_LO];
    end else begin : g_zero
      assign ext_pos[b] = 1'b0;
    end
  end

  // low-to-high scan: last hit (highest bit) wins
  always_comb begin
    sw_lvl = '0;
    for (int i = 0; i < SW_N; i++)
      if (sw_req_i[SW_LO+i]) sw_lvl = LVL_W'(i + 1);
    ext_lvl = '0;
    for (int k = 0; k < EXT_N; k++)
      if (ext_req_i[k]) ext_lvl = LVL_W'(EXT_LO + k);
  end

  assign lvl_o = (|ext_req_i) ? ext_lvl : sw_lvl;
  assign sum_o = (sw_req_i & SW_MASK) | ext_pos;
endmodule

// File: rtl/ireq_ctrl.sv
module ireq_ctrl #(
  parameter int unsigned SUM_W = 32,
  parameter int unsigned LVL_W = 5,
  parameter int unsigned AST_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [SUM_W-1:0] sum_i,
  input  logic [LVL_W-1:0] ipl_i,
  input  logic [AST_W-1:0] ast_i,
  input  logic             rfe_i,
  output logic             trap_o,
  output logic [SUM_W-1:0] isr_o,
  output logic [LVL_W-1:0] intid_o,
  output logic             ast_err_o
);
  logic chk_q, eval;

  assign eval = chk_q & ~trap_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_q     <= 1'b1;
      trap_o    <= 1'b0;
      isr_o     <= '0;
      intid_o   <= '0;
      ast_err_o <= 1'b0;
    end else begin
      ast_err_o <= eval & (|ast_i);
      if (eval) begin
        chk_q <= rfe_i;
        if (lvl_i != '0 && lvl_i > ipl_i) begin
          trap_o  <= 1'b1;
          isr_o   <= sum_i;
          intid_o <= lvl_i;
        end
      end else if (rfe_i) begin
        chk_q  <= 1'b1;
        trap_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ireq_eval.sv
module ireq_eval
  import ireq_pkg::*;
#(
  parameter int unsigned P_SUM_W  = SUM_W,
  parameter int unsigned P_LVL_W  = LVL_W,
  parameter int unsigned P_SW_LO  = SW_LO,
  parameter int unsigned P_SW_N   = SW_N,
  parameter int unsigned P_EXT_LO = EXT_LO,
  parameter int unsigned P_EXT_N  = EXT_N,
  parameter int unsigned P_AST_W  = AST_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sw_we_i,
  input  logic [P_SUM_W-1:0]  sw_wdata_i,
  input  logic [P_EXT_N-1:0]  ext_req_i,
  input  logic [P_AST_W-1:0]  ast_req_i,
  input  logic [P_LVL_W-1:0]  ipl_i,
  input  logic                rfe_i,
  output logic                trap_o,
  output logic [P_SUM_W-1:0]  isr_o,
  output logic [P_LVL_W-1:0]  intid_o,
  output logic                ast_err_o
);
  logic [P_SUM_W-1:0] sw_req, sum;
  logic [P_LVL_W-1:0] lvl;

  ireq_swreg #(.SUM_W(P_SUM_W), .SW_LO(P_SW_LO), .SW_N(P_SW_N)) u_swreg (
    .clk_i, .rst_ni, .we_i(sw_we_i), .wdata_i(sw_wdata_i), .req_o(sw_req)
  );

  ireq_prio #(.SUM_W(P_SUM_W), .LVL_W(P_LVL_W), .SW_LO(P_SW_LO), .SW_N(P_SW_N),
              .EXT_LO(P_EXT_LO), .EXT_N(P_EXT_N)) u_prio (
    .sw_req_i(sw_req), .ext_req_i, .lvl_o(lvl), .sum_o(sum)
  );

  ireq_ctrl #(.SUM_W(P_SUM_W), .LVL_W(P_LVL_W), .AST_W(P_AST_W)) u_ctrl (
    .clk_i, .rst_ni, .lvl_i(lvl), .sum_i(sum), .ipl_i, .ast_i(ast_req_i), .rfe_i,
    .trap_o, .isr_o, .intid_o, .ast_err_o
  );
endmodule

// File: rtl/ireq_eval_chk.sv
module ireq_eval_chk #(
  parameter int unsigned SUM_W  = 32,
  parameter int unsigned LVL_W  = 5,
  parameter int unsigned SW_LO  = 4,
  parameter int unsigned SW_N   = 15,
  parameter int unsigned EXT_LO = 20,
  parameter int unsigned EXT_N  = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [LVL_W-1:0] ipl_i,
  input logic             rfe_i,
  input logic             trap_o,
  input logic [SUM_W-1:0] isr_o,
  input logic [LVL_W-1:0] intid_o
);
  localparam logic [SUM_W-1:0] OK_BITS =
    SUM_W'(((64'd1 << SW_N) - 64'd1) << SW_LO) | SUM_W'(((64'd1 << EXT_N) - 64'd1) << EXT_LO);

  a_r1_summary_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (isr_o & ~OK_BITS) == '0);

  a_r6_level_above_ipl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trap_o) |-> (intid_o != '0 && intid_o > $past(ipl_i)));

  a_r5_ext_winner_in_summary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(trap_o) && intid_o >= LVL_W'(EXT_LO)) |-> isr_o[intid_o]);

  a_r8_hold_while_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o && !rfe_i) |=> (trap_o && $stable(isr_o) && $stable(intid_o)));

  a_r8_rfe_drops_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o && rfe_i) |=> !trap_o);
endmodule

bind ireq_eval ireq_eval_chk #(
  .SUM_W(P_SUM_W), .LVL_W(P_LVL_W), .SW_LO(P_SW_LO), .SW_N(P_SW_N),
  .EXT_LO(P_EXT_LO), .EXT_N(P_EXT_N)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ipl_i(ipl_i), .rfe_i(rfe_i),
  .trap_o(trap_o), .isr_o(isr_o), .intid_o(intid_o)
);

// File: tb/ireq_eval_tb_top.sv
module ireq_eval_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 5000;

  logic        clk = 0, rst_ni = 0;
  logic        sw_we = 0, rfe = 0;
  logic [31:0] sw_wdata = 0;
  logic [10:0] ext_req = 0;
  logic [3:0]  ast_req = 0;
  logic [4:0]  ipl = 0;
  logic        trap, ast_err;
  logic [31:0] isr;
  logic [4:0]  intid;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R10";

  // behavioural model state
  logic [31:0] m_sw = 0, m_isr = 0;
  logic [4:0]  m_id = 0;
  logic        m_chk = 1, m_trap = 0, m_ast = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ireq_eval dut_i (
    .clk_i(clk), .rst_ni, .sw_we_i(sw_we), .sw_wdata_i(sw_wdata), .ext_req_i(ext_req),
    .ast_req_i(ast_req), .ipl_i(ipl), .rfe_i(rfe), .trap_o(trap), .isr_o(isr),
    .intid_o(intid), .ast_err_o(ast_err)
  );

  function automatic int ref_lvl(logic [31:0] sw, logic [10:0] ext);
    int lv = 0;
    for (int i = 4; i <= 18; i++) if (sw[i]) lv = i - 3;
    if (ext != 0) for (int k = 0; k < 11; k++) if (ext[k]) lv = 20 + k;
    return lv;
  endfunction

  function automatic logic [31:0] ref_sum(logic [31:0] sw, logic [10:0] ext);
    logic [31:0] s = sw & 32'h0007_fff0;
    for (int k = 0; k < 11; k++) if (ext[k]) s[20+k] = 1'b1;
    return s;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    logic ev;
    int lv;
    ev = m_chk && !m_trap;
    lv = ref_lvl(m_sw, ext_req);
    if (ev) begin
      m_ast = (ast_req != 0);
      m_chk = rfe;
      if (lv != 0 && lv > int'(ipl)) begin
        m_trap = 1; m_isr = ref_sum(m_sw, ext_req); m_id = 5'(lv);
      end
    end else begin
      m_ast = 0;
      if (rfe) begin m_chk = 1; m_trap = 0; end
    end
    if (sw_we) m_sw = sw_wdata & 32'h0007_fff0;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(cur_req, "model", {27'd0, trap, ast_err, 3'd0}, {27'd0, m_trap, m_ast, 3'd0});
    check(cur_req, "model isr", isr, m_isr);
    check(cur_req, "model intid", {27'd0, intid}, {27'd0, m_id});
  endtask

  // write software reg, set inputs, re-arm; returns just after the evaluating edge
  task automatic run_case(logic [31:0] sw, logic [10:0] ext, logic [4:0] lv, logic [3:0] ast);
    sw_we = 1; sw_wdata = sw; ext_req = ext; ipl = lv; ast_req = ast; rfe = 1;
    tick();
    sw_we = 0; rfe = 0;
    tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10", "reset trap", {31'd0, trap}, 0);
    check("R10", "reset isr", isr, 0);
    check("R10", "reset intid", {27'd0, intid}, 0);
    check("R10", "reset ast_err", {31'd0, ast_err}, 0);
    rst_ni = 1;
    repeat (2) tick();

    cur_req = "R1";
    run_case(32'hffff_ffff, 0, 0, 0);
    check("R1", "trap", {31'd0, trap}, 1);
    check("R1", "isr mask", isr, 32'h0007_fff0);
    check("R1", "intid", {27'd0, intid}, 15);

    cur_req = "R2";
    run_case(32'h0000_0010, 0, 0, 0);
    check("R2", "lowest sw intid", {27'd0, intid}, 1);
    check("R7", "isr", isr, 32'h10);
    run_case(32'h0000_0220, 0, 0, 0);
    check("R2", "highest sw wins", {27'd0, intid}, 6);
    check("R5", "sw summary", isr, 32'h220);

    cur_req = "R3";
    run_case(0, 11'b000_0000_1001, 0, 0);
    check("R3", "ext intid", {27'd0, intid}, 23);
    check("R5", "ext summary", isr, 32'h0090_0000);

    cur_req = "R4";
    run_case(32'h0004_0000, 11'b1, 0, 0);
    check("R4", "ext over sw", {27'd0, intid}, 20);
    check("R5", "mixed summary", isr, 32'h0014_0000);

    cur_req = "R6";
    run_case(32'h0000_0200, 0, 6, 0);
    check("R6", "equal ipl no trap", {31'd0, trap}, 0);
    check("R6", "isr kept", isr, 32'h0014_0000);
    check("R6", "intid kept", {27'd0, intid}, 20);
    run_case(32'h0000_0200, 0, 5, 0);
    check("R6", "lower ipl traps", {31'd0, trap}, 1);
    check("R6", "intid", {27'd0, intid}, 6);
    run_case(0, 0, 0, 0);
    check("R6", "level zero no trap", {31'd0, trap}, 0);

    cur_req = "R8";
    run_case(32'h0000_0010, 0, 0, 0);
    ext_req = 11'h7ff;
    repeat (3) tick();
    check("R8", "trap held", {31'd0, trap}, 1);
    check("R8", "intid held", {27'd0, intid}, 1);
    run_case(0, 0, 31, 0);
    check("R8", "no trap at max ipl", {31'd0, trap}, 0);
    ipl = 0; ext_req = 11'h400;
    repeat (3) tick();
    check("R8", "flag cleared no eval", {31'd0, trap}, 0);
    rfe = 1; tick(); rfe = 0; tick();
    check("R8", "rearm evaluates", {27'd0, intid}, 30);

    cur_req = "R9";
    run_case(32'h0000_0010, 0, 0, 4'h2);
    check("R9", "ast pulse", {31'd0, ast_err}, 1);
    tick();
    check("R9", "ast pulse ends", {31'd0, ast_err}, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule